// File: doc/BRIEF.md
# NAND Flash Command Interpreter

This block is the device-side front end of a NAND flash model. It watches the multiplexed byte bus at every write-strobe rising edge while the chip select is low, and sorts each byte into one of three kinds: a command when the command-latch line is high, an address when the address-latch line is high, and data when neither is high. It checks every command against a small grammar. Single-cycle commands act at once. Two-step commands gather their address bytes and wait for a confirm opcode before they start an internal operation.

A started operation pulls ready/busy low for a number of clock cycles set by a parameter for each operation type. When the time is up, the operation takes effect on a small page store. A read copies a page into the page register. A program copies the page register into a page. An erase fills a whole block with 0xFF. The read strobe returns status, identification or page-register bytes, depending on the current output mode. Each page-register byte moves the column pointer forward by one. The random-output command sets the column pointer to a new place inside the page that is already loaded.

Top module: `nand_cmd_interp`

## Requirements
- R1: A byte is taken only at a rising edge of we_n_i while ce_n_i is low. cle_i high makes it a command, ale_i high makes it an address, and a byte with neither line high is data. A byte strobed while ce_n_i is high has no effect.
- R2: Opcode 0xFF is accepted at any time. It drops any pending sequence, abandons a running operation without applying it, selects status output, and holds rb_o low for T_RESET cycles.
- R3: Opcodes 0x70 and 0xF1 select status output at any time. The status byte has bit 6 = 1 when ready, bit 0 = 1 when the last read, program or erase failed, and all other bits 0.
- R4: Opcode 0x90 (only when not busy) selects identification output. Successive read strobes return the bytes of ID_CODE from the least significant byte up, and wrap after ID_LEN bytes.
- R5: Read is 0x00, two column bytes (low byte first), ROW_CYC row bytes, then 0x30. rb_o stays low for exactly T_READ cycles. After that the page is in the page register, the column pointer is at the given column, and data output is selected.
- R6: Program is 0x80, which presets the page register to 0xFF, then the same address bytes, data bytes written from the given column upward, then 0x10. rb_o stays low for exactly T_PROG cycles, and after that the page holds the page register.
- R7: Erase is 0x60, ROW_CYC row bytes, then 0xD0. rb_o stays low for exactly T_ERASE cycles, and after that every page of the block that holds the row (PAGES_PER_BLK pages per block) reads 0xFF.
- R8: While busy, every command other than 0xFF, 0x70 and 0xF1 is ignored, and so are all address and data bytes.
- R9: Address bytes beyond the number the current sequence needs are ignored.
- R10: Each falling edge of re_n_i with ce_n_i low puts the next byte on io_o. In data output it moves the column pointer forward by one, wrapping at the end of the page. Data writes during program also move the pointer and wrap.
- R11: Random output, which is 0x05, two column bytes, then 0xE0, moves the column pointer inside the loaded page and selects data output without any busy time.
- R12: Taking ce_n_i high while busy neither aborts nor shortens the running operation.
- R13: An unsupported opcode, a confirm opcode that does not match the pending sequence, or a confirm given before all address bytes have arrived returns the grammar to idle. It starts nothing and changes no stored data.
- R14: A row address at or above NUM_PAGES still takes its full busy time, but it leaves the store unchanged and sets the fail bit. A later in-range operation clears the fail bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Chip select, active low |
| cle_i | input | 1 | Marks a command byte |
| ale_i | input | 1 | Marks an address byte |
| we_n_i | input | 1 | Write strobe; byte taken at its rising edge |
| re_n_i | input | 1 | Read strobe; next byte at its falling edge |
| io_i | input | 8 | Incoming bus byte |
| io_o | output | 8 | Outgoing bus byte |
| io_oe_o | output | 1 | Output enable for io_o |
| rb_o | output | 1 | Ready (1) / busy (0) |

## Verification
The hardest situations to reach are the ones that depend on a running operation: commands and address bytes that arrive while busy, a reset that cuts a program short, and a chip-select release in the middle of the busy window. The stimulus reaches them by starting a program with a long busy time and then sending a full read sequence, an identification opcode and a status opcode before rb_o rises. A later readback shows which of these left a mark. Wrap-around is reached by starting a program two bytes before the end of a page and reading the same span back.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;
  localparam logic [7:0] OPC_RESET  = 8'hFF;
  localparam logic [7:0] OPC_STAT_A = 8'h70;
  localparam logic [7:0] OPC_STAT_B = 8'hF1;
  localparam logic [7:0] OPC_ID     = 8'h90;
  localparam logic [7:0] OPC_RD_SET = 8'h00;
  localparam logic [7:0] OPC_RD_GO  = 8'h30;
  localparam logic [7:0] OPC_PG_SET = 8'h80;
  localparam logic [7:0] OPC_PG_GO  = 8'h10;
  localparam logic [7:0] OPC_ER_SET = 8'h60;
  localparam logic [7:0] OPC_ER_GO  = 8'hD0;
  localparam logic [7:0] OPC_RO_SET = 8'h05;
  localparam logic [7:0] OPC_RO_GO  = 8'hE0;

  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_PG, ST_ER, ST_RO} gram_e;
  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_PROG, OP_ERASE} op_e;
  typedef enum logic [1:0] {OM_DATA, OM_STATUS, OM_ID} omode_e;
endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_n_i,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       we_n_i,
  input  logic       re_n_i,
  output logic       cmd_v_o,
  output logic       addr_v_o,
  output logic       data_v_o,
  output logic       rd_fall_o
);
  logic we_q, re_q, we_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_n_i;
      re_q <= re_n_i;
    end
  end

  assign we_rise   = !we_q && we_n_i && !ce_n_i;
  assign cmd_v_o   = we_rise && cle_i && !ale_i;
  assign addr_v_o  = we_rise && ale_i && !cle_i;
  assign data_v_o  = we_rise && !cle_i && !ale_i;
  assign rd_fall_o = re_q && !re_n_i && !ce_n_i;

  assert_strobe_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_v_o || addr_v_o || data_v_o) |-> ($past(we_n_i) == 1'b0 && !ce_n_i));
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer
  import nand_cmd_pkg::*;
#(
  parameter int T_READ  = 20,
  parameter int T_PROG  = 40,
  parameter int T_ERASE = 60,
  parameter int T_RESET = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  op_e  op_i,
  output logic busy_o,
  output logic done_o,
  output op_e  done_op_o
);
  localparam int TMAX_A = (T_READ > T_PROG) ? T_READ : T_PROG;
  localparam int TMAX_B = (T_ERASE > T_RESET) ? T_ERASE : T_RESET;
  localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int CNT_W  = $clog2(TMAX + 1);

  logic [CNT_W-1:0] cnt_q, dur;
  op_e op_q;

  always_comb begin
    case (op_i)
      OP_READ:  dur = CNT_W'(T_READ);
      OP_PROG:  dur = CNT_W'(T_PROG);
      OP_ERASE: dur = CNT_W'(T_ERASE);
      default:  dur = CNT_W'(T_RESET);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      op_q  <= OP_NONE;
    end else if (start_i) begin
      cnt_q <= dur;
      op_q  <= op_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o    = cnt_q != '0;
  assign done_o    = cnt_q == CNT_W'(1);
  assign done_op_o = op_q;

  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
endmodule

// File: rtl/nand_page_store.sv
module nand_page_store #(
  parameter int PAGE_BYTES    = 16,
  parameter int NUM_PAGES     = 8,
  parameter int PAGES_PER_BLK = 2,
  localparam int COL_W = $clog2(PAGE_BYTES),
  localparam int PG_W  = $clog2(NUM_PAGES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [7:0]       din_i,
  input  logic             load_i,
  input  logic             prog_i,
  input  logic             erase_i,
  input  logic [PG_W-1:0]  row_i,
  output logic [7:0]       dout_o
);
  localparam int BLK_SH = $clog2(PAGES_PER_BLK);

  logic [7:0] mem  [NUM_PAGES][PAGE_BYTES];
  logic [7:0] preg [PAGE_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PAGES; p++)
        for (int c = 0; c < PAGE_BYTES; c++) mem[p][c] <= 8'hFF;
    end else begin
      for (int p = 0; p < NUM_PAGES; p++)
        for (int c = 0; c < PAGE_BYTES; c++)
          if (erase_i && ((p >> BLK_SH) == (int'(row_i) >> BLK_SH))) mem[p][c] <= 8'hFF;
          else if (prog_i && p == int'(row_i)) mem[p][c] <= preg[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < PAGE_BYTES; c++) preg[c] <= 8'hFF;
    end else begin
      for (int c = 0; c < PAGE_BYTES; c++)
        if (clr_i) preg[c] <= 8'hFF;
        else if (load_i) preg[c] <= mem[row_i][c];
        else if (we_i && c == int'(col_i)) preg[c] <= din_i;
    end
  end

  assign dout_o = preg[col_i];
endmodule

// File: rtl/nand_cmd_interp.sv
module nand_cmd_interp
  import nand_cmd_pkg::*;
#(
  parameter int PAGE_BYTES    = 16,
  parameter int NUM_PAGES     = 8,
  parameter int PAGES_PER_BLK = 2,
  parameter int ROW_CYC       = 1,
  parameter int T_READ        = 20,
  parameter int T_PROG        = 40,
  parameter int T_ERASE       = 60,
  parameter int T_RESET       = 5,
  parameter int ID_LEN        = 5,
  parameter logic [8*ID_LEN-1:0] ID_CODE = 40'hC5_7E_19_A3_D2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_n_i,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       we_n_i,
  input  logic       re_n_i,
  input  logic [7:0] io_i,
  output logic [7:0] io_o,
  output logic       io_oe_o,
  output logic       rb_o
);
  localparam int COL_CYC  = 2;
  localparam int ADDR_MAX = COL_CYC + ROW_CYC;
  localparam int ACNT_W   = $clog2(ADDR_MAX + 1);
  localparam int COL_W    = $clog2(PAGE_BYTES);
  localparam int PG_W     = $clog2(NUM_PAGES);
  localparam int ROW_W    = 8 * ROW_CYC;
  localparam int IDX_W    = (ID_LEN > 1) ? $clog2(ID_LEN) : 1;

  logic cmd_v, addr_v, data_v, rd_fall;
  logic busy, tmr_done, tmr_start;
  op_e  tmr_op, done_op;

  gram_e state_q, state_n;
  omode_e omode_q;
  logic [ACNT_W-1:0] acnt_q, need;
  logic [7:0] addr_b [ADDR_MAX];
  logic [COL_W-1:0] col_q, pcol_q, col_full, col_pg;
  logic [PG_W-1:0] row_q;
  logic [ROW_W-1:0] row_full;
  logic row_ok_q, fail_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0] io_q, pr_dout;
  logic full, busy_ok, acnt_clr, latch, pr_clr, pr_we, set_status, set_id, ro_go;
  logic ok_done, rd_done;

  nand_bus_sampler u_smp (
    .clk_i, .rst_ni, .ce_n_i, .cle_i, .ale_i, .we_n_i, .re_n_i,
    .cmd_v_o(cmd_v), .addr_v_o(addr_v), .data_v_o(data_v), .rd_fall_o(rd_fall)
  );

  nand_busy_timer #(.T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE), .T_RESET(T_RESET)) u_tmr (
    .clk_i, .rst_ni, .start_i(tmr_start), .op_i(tmr_op),
    .busy_o(busy), .done_o(tmr_done), .done_op_o(done_op)
  );

  assign ok_done = tmr_done && row_ok_q;
  assign rd_done = tmr_done && done_op == OP_READ;

  nand_page_store #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES), .PAGES_PER_BLK(PAGES_PER_BLK)) u_store (
    .clk_i, .rst_ni, .clr_i(pr_clr), .we_i(pr_we), .col_i(col_q), .din_i(io_i),
    .load_i(ok_done && done_op == OP_READ), .prog_i(ok_done && done_op == OP_PROG),
    .erase_i(ok_done && done_op == OP_ERASE), .row_i(row_q), .dout_o(pr_dout)
  );

  always_comb begin
    case (state_q)
      ST_RD, ST_PG: need = ACNT_W'(ADDR_MAX);
      ST_ER:        need = ACNT_W'(ROW_CYC);
      ST_RO:        need = ACNT_W'(COL_CYC);
      default:      need = '0;
    endcase
    for (int k = 0; k < ROW_CYC; k++)
      row_full[8*k +: 8] = (state_q == ST_ER) ? addr_b[k] : addr_b[k + COL_CYC];
  end

  assign full     = (need != '0) && (acnt_q == need);
  assign col_full = COL_W'({addr_b[1], addr_b[0]});
  assign col_pg   = COL_W'({io_i, addr_b[0]});
  assign busy_ok  = io_i == OPC_RESET || io_i == OPC_STAT_A || io_i == OPC_STAT_B;
  assign pr_we    = data_v && !busy && state_q == ST_PG && full;

  // command grammar
  always_comb begin
    state_n = state_q; acnt_clr = 1'b0; tmr_start = 1'b0; tmr_op = OP_NONE;
    latch = 1'b0; pr_clr = 1'b0; set_status = 1'b0; set_id = 1'b0; ro_go = 1'b0;
    if (cmd_v) begin
      if (io_i == OPC_RESET) begin
        state_n = ST_IDLE; acnt_clr = 1'b1; tmr_start = 1'b1; set_status = 1'b1;
      end else if (io_i == OPC_STAT_A || io_i == OPC_STAT_B) begin
        set_status = 1'b1;
      end else if (!busy) begin
        state_n = ST_IDLE;
        case (io_i)
          OPC_ID:     set_id = 1'b1;
          OPC_RD_SET: begin state_n = ST_RD; acnt_clr = 1'b1; end
          OPC_PG_SET: begin state_n = ST_PG; acnt_clr = 1'b1; pr_clr = 1'b1; end
          OPC_ER_SET: begin state_n = ST_ER; acnt_clr = 1'b1; end
          OPC_RO_SET: begin state_n = ST_RO; acnt_clr = 1'b1; end
          OPC_RD_GO:  if (state_q == ST_RD && full) begin tmr_start = 1'b1; tmr_op = OP_READ;  latch = 1'b1; end
          OPC_PG_GO:  if (state_q == ST_PG && full) begin tmr_start = 1'b1; tmr_op = OP_PROG;  latch = 1'b1; end
          OPC_ER_GO:  if (state_q == ST_ER && full) begin tmr_start = 1'b1; tmr_op = OP_ERASE; latch = 1'b1; end
          OPC_RO_GO:  ro_go = state_q == ST_RO && full;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; acnt_q <= '0; row_q <= '0; pcol_q <= '0;
      row_ok_q <= 1'b1; fail_q <= 1'b0;
      for (int k = 0; k < ADDR_MAX; k++) addr_b[k] <= '0;
    end else begin
      state_q <= state_n;
      if (acnt_clr) acnt_q <= '0;
      else if (addr_v && !busy && acnt_q < need) begin
        addr_b[acnt_q] <= io_i;
        acnt_q <= acnt_q + 1'b1;
      end
      if (latch) begin
        row_q    <= PG_W'(row_full);
        row_ok_q <= row_full < ROW_W'(NUM_PAGES);
        pcol_q   <= col_full;
      end
      if (tmr_done && done_op != OP_NONE) fail_q <= !row_ok_q;
    end
  end

  // column pointer, output mode and bus output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0; omode_q <= OM_DATA; idx_q <= '0; io_q <= '0;
    end else begin
      if (rd_done) col_q <= pcol_q;
      else if (ro_go) col_q <= col_full;
      else if (addr_v && !busy && state_q == ST_PG && acnt_q == ACNT_W'(1)) col_q <= col_pg;
      else if (pr_we || (rd_fall && omode_q == OM_DATA)) col_q <= col_q + 1'b1;

      if (set_status) omode_q <= OM_STATUS;
      else if (set_id) omode_q <= OM_ID;
      else if (ro_go || rd_done) omode_q <= OM_DATA;

      if (set_id) idx_q <= '0;
      else if (rd_fall && omode_q == OM_ID)
        idx_q <= (idx_q == IDX_W'(ID_LEN - 1)) ? '0 : idx_q + 1'b1;

      if (rd_fall) begin
        case (omode_q)
          OM_STATUS: io_q <= {1'b0, !busy, 5'b0, fail_q};
          OM_ID:     io_q <= ID_CODE[8*idx_q +: 8];
          default:   io_q <= pr_dout;
        endcase
      end
    end
  end

  assign io_o    = io_q;
  assign io_oe_o = !ce_n_i && !re_n_i;
  assign rb_o    = !busy;

  assert_busy_filter_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_v && !busy_ok) |=> ($stable(state_q) && $stable(acnt_q)));

  assert_addr_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_v && !busy && acnt_q == need) |=> ($stable(acnt_q) && $stable(addr_b[0])));

  assert_col_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fall && omode_q == OM_DATA && !cmd_v && !addr_v && !data_v && !tmr_done)
      |=> col_q == $past(col_q) + 1'b1);

  assert_busy_shift_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !tmr_done) |=> !rb_o);
endmodule

// File: tb/tb_nand_cmd_interp.sv
`timescale 1ns/1ps
module tb_nand_cmd_interp;
  localparam int T_READ = 20, T_PROG = 40, T_ERASE = 60, T_RESET = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
  logic [7:0] io_in = '0;
  logic [7:0] io_out;
  logic io_oe, rb;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  nand_cmd_interp #(.T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE), .T_RESET(T_RESET)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_n_i(ce_n), .cle_i(cle), .ale_i(ale),
    .we_n_i(we_n), .re_n_i(re_n), .io_i(io_in), .io_o(io_out), .io_oe_o(io_oe), .rb_o(rb)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic a, input logic [7:0] b, input logic cs_hi);
    @(negedge clk); ce_n = cs_hi; cle = c; ale = a; io_in = b; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);  bus_wr(1'b1, 1'b0, b, 1'b0); endtask
  task automatic adr(input logic [7:0] b);  bus_wr(1'b0, 1'b1, b, 1'b0); endtask
  task automatic dat(input logic [7:0] b);  bus_wr(1'b0, 1'b0, b, 1'b0); endtask

  task automatic rd_byte(output logic [7:0] v);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); v = io_out; re_n = 1'b1;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (rb == 1'b0 && n < 10000) begin n++; @(negedge clk); end
  endtask

  task automatic do_read(input logic [7:0] col, input logic [7:0] row);
    int n;
    cmd(8'h00); adr(col); adr(8'h00); adr(row); cmd(8'h30);
    busy_len(n);
  endtask

  task automatic expect_bytes(input string req, input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2);
    logic [7:0] v;
    rd_byte(v); chk(req, v, e0);
    rd_byte(v); chk(req, v, e1);
    rd_byte(v); chk(req, v, e2);
  endtask

  task automatic t_reset_state;
    logic [7:0] v;
    chk("R3 rb after reset", rb, 1);
    chk("R3 oe idle", io_oe, 0);
    cmd(8'h70); rd_byte(v); chk("R3 status idle", v, 8'h40);
    cmd(8'hF1); rd_byte(v); chk("R3 status alt opcode", v, 8'h40);
  endtask

  task automatic t_read_id;
    logic [7:0] v;
    logic [7:0] exp [6] = '{8'hD2, 8'hA3, 8'h19, 8'h7E, 8'hC5, 8'hD2};
    cmd(8'h90);
    for (int i = 0; i < 6; i++) begin rd_byte(v); chk("R4 id byte", v, exp[i]); end
  endtask

  task automatic t_program_read;
    int n; logic [7:0] v;
    cmd(8'h80); adr(8'h03); adr(8'h00); adr(8'h02);
    for (int i = 0; i < 5; i++) dat(8'hA0 + 8'(i));
    cmd(8'h10); busy_len(n);
    chk("R6 program busy length", n, T_PROG);
    cmd(8'h70); rd_byte(v); chk("R3 status after program", v, 8'h40);
    cmd(8'h00); adr(8'h03); adr(8'h00); adr(8'h02); cmd(8'h30); busy_len(n);
    chk("R5 read busy length", n, T_READ);
    expect_bytes("R5 read data", 8'hA0, 8'hA1, 8'hA2);
    expect_bytes("R10 sequential data", 8'hA3, 8'hA4, 8'hFF);
    do_read(8'h00, 8'h02);
    expect_bytes("R6 preset bytes", 8'hFF, 8'hFF, 8'hFF);
  endtask

  task automatic t_random_out;
    int n; logic [7:0] v;
    cmd(8'h05); adr(8'h04); adr(8'h00); cmd(8'hE0);
    n = rb; chk("R11 no busy", n, 1);
    rd_byte(v); chk("R11 reposition", v, 8'hA1);
    rd_byte(v); chk("R11 advance after reposition", v, 8'hA2);
  endtask

  task automatic t_wrap;
    int n;
    cmd(8'h80); adr(8'h0E); adr(8'h00); adr(8'h03);
    dat(8'h11); dat(8'h22); dat(8'h33); cmd(8'h10); busy_len(n);
    do_read(8'h0E, 8'h03);
    expect_bytes("R10 column wrap", 8'h11, 8'h22, 8'h33);
  endtask

  task automatic t_extra_addr;
    int n;
    cmd(8'h00); adr(8'h03); adr(8'h00); adr(8'h02); adr(8'h05); adr(8'h06); cmd(8'h30);
    busy_len(n);
    chk("R9 extra address busy", n, T_READ);
    expect_bytes("R9 extra address ignored", 8'hA0, 8'hA1, 8'hA2);
  endtask

  task automatic t_busy_filter;
    int n; logic [7:0] v;
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h04); dat(8'h5A); cmd(8'h10);
    cmd(8'h00); adr(8'h03); adr(8'h00); adr(8'h02); cmd(8'h30); cmd(8'h90);
    cmd(8'h70); rd_byte(v); chk("R3 status while busy", v, 8'h00);
    busy_len(n);
    rd_byte(v); chk("R8 id ignored while busy", v, 8'h40);
    cmd(8'h30); @(negedge clk);
    chk("R8 read sequence dropped", rb, 1);
    do_read(8'h00, 8'h04);
    expect_bytes("R8 program kept", 8'h5A, 8'hFF, 8'hFF);
  endtask

  task automatic t_ce_busy;
    int n; logic [7:0] v;
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h05); dat(8'h77); cmd(8'h10);
    ce_n = 1'b1; busy_len(n); ce_n = 1'b0;
    chk("R12 busy kept with chip deselected", n, T_PROG);
    cmd(8'h70);
    bus_wr(1'b1, 1'b0, 8'h90, 1'b1);
    rd_byte(v); chk("R1 deselected byte ignored", v, 8'h40);
    do_read(8'h00, 8'h05);
    rd_byte(v); chk("R12 program completed", v, 8'h77);
  endtask

  task automatic t_erase;
    int n; logic [7:0] v;
    cmd(8'h60); adr(8'h04); cmd(8'hD0); busy_len(n);
    chk("R7 erase busy length", n, T_ERASE);
    do_read(8'h00, 8'h04); rd_byte(v); chk("R7 page 4 erased", v, 8'hFF);
    do_read(8'h00, 8'h05); rd_byte(v); chk("R7 page 5 erased", v, 8'hFF);
    do_read(8'h03, 8'h02); rd_byte(v); chk("R7 other block kept", v, 8'hA0);
  endtask

  task automatic t_reset_abort;
    int n; logic [7:0] v;
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h06); dat(8'h99); cmd(8'h10);
    cmd(8'hFF); busy_len(n);
    chk("R2 reset busy length", n, T_RESET);
    rd_byte(v); chk("R2 status mode after reset", v, 8'h40);
    do_read(8'h00, 8'h06); rd_byte(v); chk("R2 program abandoned", v, 8'hFF);
  endtask

  task automatic t_bad_grammar;
    logic [7:0] v;
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h07); dat(8'h12); cmd(8'h3A); cmd(8'h10);
    @(negedge clk); chk("R13 unsupported opcode", rb, 1);
    cmd(8'h00); adr(8'h00); adr(8'h00); adr(8'h02); cmd(8'hD0);
    @(negedge clk); chk("R13 wrong confirm", rb, 1);
    cmd(8'h60); cmd(8'hD0);
    @(negedge clk); chk("R13 short address", rb, 1);
    do_read(8'h00, 8'h07); rd_byte(v); chk("R13 page untouched", v, 8'hFF);
  endtask

  task automatic t_out_of_range;
    int n; logic [7:0] v;
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h09); dat(8'h44); cmd(8'h10); busy_len(n);
    chk("R14 busy length", n, T_PROG);
    cmd(8'h70); rd_byte(v); chk("R14 fail bit", v, 8'h41);
    do_read(8'h00, 8'h01); rd_byte(v); chk("R14 aliased page untouched", v, 8'hFF);
    cmd(8'h70); rd_byte(v); chk("R14 fail cleared", v, 8'h40);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_read_id();
    t_program_read();
    t_random_out();
    t_wrap();
    t_extra_addr();
    t_busy_filter();
    t_ce_busy();
    t_erase();
    t_reset_abort();
    t_bad_grammar();
    t_out_of_range();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule